// File: doc/BRIEF.md
# Slot-Based Serial Data Transmitter

This block turns a stream of parallel audio words into one serial data line organised as frames of numbered slots. A frame begins when a frame-sync input is seen together with a bit-tick enable. Each later tick moves the line on by one bit position. Every frame holds a configurable number of slots, and every slot holds a configurable number of bit positions.

A per-slot enable mask decides which slots carry data. An enabled slot takes the next word from a small input queue and sends its low `data_bits` bits most significant bit first. A disabled slot takes nothing from the queue. Bit positions that carry no data are idle. Idle positions include disabled slots, the tail of a slot that is wider than its data, and the time outside a frame. A single configuration bit chooses how idle positions are shown: either the output enable is released (high impedance) or the line is driven low.

The frame geometry is captured at the frame-sync tick, so software may rewrite it while a frame is in progress. If an enabled slot starts while the queue is empty, the slot is sent as zeros and a one-cycle underrun pulse is raised.

Top module: `tdm_slot_tx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ser_oe`=0, `ser_out`=0, `underrun`=0 and `word_ready`=1.
- R2: Outputs are registered and change only on clock edges where `bit_tick`=1. A tick with `frame_sync`=1 presents slot 0, bit 0 after that edge. Each following tick advances one bit. After bit `slot_bits`-1 of slot `slots_per_frame`-1, the line stays idle until the next frame-sync tick.
- R3: Slot i is enabled when bit i of `slot_enable_mask` is 1. At bit 0 of an enabled slot, the oldest queued word is popped. Its bits [`data_bits`-1:0] are then sent most significant bit first, with `ser_oe`=1. Disabled slots pop nothing.
- R4: With `idle_hiz`=1, every idle bit position gives `ser_oe`=0 and `ser_out`=0. Idle positions are disabled slots, positions at or after `data_bits` inside a slot, and positions outside a frame.
- R5: With `idle_hiz`=0, every idle bit position gives `ser_oe`=1 and `ser_out`=0.
- R6: `slot_bits` may exceed `data_bits`. Both are bit counts from 1 to WORD_W, with `data_bits` ≤ `slot_bits`. The extra tail bits of a slot are idle.
- R7: If an enabled slot starts with the queue empty, the slot's data positions are driven as 0 with `ser_oe`=1. `underrun` is high for exactly the one cycle after that slot's bit-0 tick.
- R8: `slots_per_frame` (a count from 1 to MAX_SLOTS), `slot_bits`, `data_bits`, `slot_enable_mask` and `idle_hiz` are sampled at the frame-sync tick. Changes made during a frame take effect at the next frame.
- R9: `word_ready` is 1 while the queue holds fewer than FIFO_DEPTH words. A word is accepted when `word_valid` and `word_ready` are both 1. Words leave the queue in arrival order.
- R10: A frame-sync tick in the middle of a frame restarts the frame at slot 0, bit 0. The word of the interrupted slot is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One serial bit position per cycle where high |
| frame_sync | input | 1 | Marks the start of a frame; used only together with bit_tick |
| slot_enable_mask | input | MAX_SLOTS | Bit i enables slot i |
| slots_per_frame | input | $clog2(MAX_SLOTS+1) | Slots in a frame, 1..MAX_SLOTS |
| slot_bits | input | $clog2(WORD_W+1) | Bit positions per slot, 1..WORD_W |
| data_bits | input | $clog2(WORD_W+1) | Data bits per word, 1..slot_bits |
| idle_hiz | input | 1 | 1: idle positions released; 0: idle positions driven low |
| word_in | input | WORD_W | Data word to queue |
| word_valid | input | 1 | word_in holds a word |
| word_ready | output | 1 | Queue can accept a word |
| ser_out | output | 1 | Serial data |
| ser_oe | output | 1 | Output enable for ser_out |
| underrun | output | 1 | One-cycle pulse when an enabled slot starts with no word |

## Verification
A slot or bit counter that slips shows up at `ser_oe` within one tick. The symptom is the line going idle or driving data where the frame geometry says otherwise, or an early or late return to idle at frame end. A queue pointer fault shows up as a wrong word, or a word out of order, in the very next enabled slot. It also shows up as a `word_ready` that disagrees with the number of accepted words in the same cycle. The reference model is compared on every cycle, including cycles with no tick. Because of that, a register that updates without a tick is caught on the first such cycle.

// File: rtl/tdm_slot_tx_pkg.sv
// Package: shared types for the slot-based serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package tdm_slot_tx_pkg;

    // Class of the bit position being sent on a tick.
    typedef enum logic {
        POS_IDLE = 1'b0,
        POS_DATA = 1'b1
    } pos_kind_e;

    // Output-enable value for an idle position given the release setting.
    function automatic logic idle_oe(input logic release_line);
        return ~release_line;
    endfunction

endpackage

// File: rtl/tdm_word_fifo.sv
// Module: tdm_word_fifo
// A first-word-fall-through queue of data words. The head is visible while
// the queue is not empty. Push and pop may happen in the same cycle.
// Assumes: DEPTH is a power of two, at least 2; the caller never pushes
// when full and never pops when empty.
module tdm_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;

    // Write the incoming word into the slot addressed by the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr[AW-1:0]] <= push_data;
        end
    end

    // Advance the read and write pointers; the extra top bit tells full from empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Derive the head word and the occupancy flags.
    always_comb begin
        head  = store[rd_ptr[AW-1:0]];
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    end

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R9
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R7

endmodule

// File: rtl/tdm_frame_tracker.sv
// Module: tdm_frame_tracker
// Tracks the slot and bit position of each tick within a frame. It captures
// the frame configuration at the frame-sync tick. Its outputs describe the
// position the current tick will present, so the caller can register the
// serial bit on the same edge.
// Assumes: MAX_SLOTS is a power of two; slot count, slot size and data size
// are non-zero, and data size does not exceed slot size.
module tdm_frame_tracker #(
    parameter int MAX_SLOTS = 16,
    parameter int WORD_W    = 32,
    localparam int CNT_W    = $clog2(MAX_SLOTS + 1),
    localparam int SLOT_W   = $clog2(MAX_SLOTS),
    localparam int LEN_W    = $clog2(WORD_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 sync,
    input  logic [MAX_SLOTS-1:0] cfg_mask,
    input  logic [CNT_W-1:0]     cfg_slots,
    input  logic [LEN_W-1:0]     cfg_slot_len,
    input  logic [LEN_W-1:0]     cfg_data_len,
    input  logic                 cfg_release,
    output logic                 pos_start,
    output logic                 pos_data,
    output logic [LEN_W-1:0]     pos_bit,
    output logic [LEN_W-1:0]     eff_data_len,
    output logic                 eff_release
);
    // Position last presented on the line.
    logic                 in_frame_q;
    logic [SLOT_W-1:0]    slot_q;
    logic [LEN_W-1:0]     bit_q;

    // Frame configuration captured at frame sync.
    logic [MAX_SLOTS-1:0] lat_mask;
    logic [CNT_W-1:0]     lat_slots;
    logic [LEN_W-1:0]     lat_slot_len;
    logic [LEN_W-1:0]     lat_data_len;
    logic                 lat_release;

    // Position of the current tick.
    logic                 nxt_valid;
    logic [SLOT_W-1:0]    nxt_slot;
    logic [LEN_W-1:0]     nxt_bit;
    logic                 last_bit;
    logic                 last_slot;

    // Configuration that applies to the current tick.
    logic [MAX_SLOTS-1:0] use_mask;
    logic                 slot_on;

    // Detect the end of a slot and the end of a frame from the held position.
    always_comb begin
        last_bit  = (bit_q == LEN_W'(lat_slot_len - 1'b1));
        last_slot = (CNT_W'(slot_q) == CNT_W'(lat_slots - 1'b1));
    end

    // Step the position: restart on sync, else advance within the open frame.
    always_comb begin
        nxt_valid = 1'b0;
        nxt_slot  = slot_q;
        nxt_bit   = bit_q;
        if (sync) begin
            nxt_valid = 1'b1;
            nxt_slot  = '0;
            nxt_bit   = '0;
        end else if (in_frame_q) begin
            if (last_bit) begin
                if (!last_slot) begin
                    nxt_valid = 1'b1;
                    nxt_slot  = slot_q + 1'b1;
                    nxt_bit   = '0;
                end
            end else begin
                nxt_valid = 1'b1;
                nxt_bit   = bit_q + 1'b1;
            end
        end
    end

    // Pick live configuration on a sync tick, captured configuration otherwise.
    always_comb begin
        use_mask     = sync ? cfg_mask     : lat_mask;
        eff_data_len = sync ? cfg_data_len : lat_data_len;
        eff_release  = sync ? cfg_release  : lat_release;
        slot_on      = nxt_valid && use_mask[nxt_slot];
        pos_start    = slot_on && (nxt_bit == '0);
        pos_data     = slot_on && (nxt_bit < eff_data_len);
        pos_bit      = nxt_bit;
    end

    // Hold the position presented by each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            slot_q     <= '0;
            bit_q      <= '0;
        end else if (tick) begin
            in_frame_q <= nxt_valid;
            slot_q     <= nxt_slot;
            bit_q      <= nxt_bit;
        end
    end

    // Capture the frame configuration on a sync tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_mask     <= '0;
            lat_slots    <= CNT_W'(1);
            lat_slot_len <= LEN_W'(1);
            lat_data_len <= LEN_W'(1);
            lat_release  <= 1'b1;
        end else if (tick && sync) begin
            lat_mask     <= cfg_mask;
            lat_slots    <= cfg_slots;
            lat_slot_len <= cfg_slot_len;
            lat_data_len <= cfg_data_len;
            lat_release  <= cfg_release;
        end
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame_q |-> (CNT_W'(slot_q) < lat_slots));  // R2
    AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame_q |-> (bit_q < lat_slot_len));  // R2
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && sync) |=> $stable(lat_slots) && $stable(lat_slot_len));  // R8

endmodule

// File: rtl/tdm_bit_driver.sv
// Module: tdm_bit_driver
// Loads a word at the start of each enabled slot, selects the bit for the
// current position and registers the serial data, output enable and underrun
// pulse. It inserts a zero word when the queue is empty at slot start.
// Assumes: the position inputs come from the frame tracker for the same tick.
module tdm_bit_driver
    import tdm_slot_tx_pkg::*;
#(
    parameter int WORD_W   = 32,
    localparam int LEN_W   = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pos_start,
    input  logic              pos_data,
    input  logic [LEN_W-1:0]  pos_bit,
    input  logic [LEN_W-1:0]  data_len,
    input  logic              release_line,
    input  logic              q_empty,
    input  logic [WORD_W-1:0] q_head,
    output logic              q_pop,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              underrun
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] shifted;
    logic [LEN_W-1:0]  bit_idx;
    logic              starved;
    logic              data_bit;
    pos_kind_e         kind;
    logic              past_ok;

    // Choose the word for this tick: a fresh load at slot start, else the held one.
    always_comb begin
        starved  = pos_start && q_empty;
        q_pop    = tick && pos_start && !q_empty;
        cur_word = pos_start ? (q_empty ? '0 : q_head) : word_q;
        bit_idx  = LEN_W'(data_len - pos_bit - 1'b1);
        shifted  = cur_word >> bit_idx;
        data_bit = shifted[0];
        kind     = pos_data ? POS_DATA : POS_IDLE;
    end

    // Hold the slot word across the slot's remaining bit positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (tick && pos_start) begin
            word_q <= cur_word;
        end
    end

    // Register the serial line and its enable on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
            ser_oe  <= 1'b0;
        end else if (tick) begin
            if (kind == POS_DATA) begin
                ser_out <= data_bit;
                ser_oe  <= 1'b1;
            end else begin
                ser_out <= 1'b0;
                ser_oe  <= idle_oe(release_line);
            end
        end
    end

    // Raise a one-cycle underrun when an enabled slot starts with no word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else begin
            underrun <= tick && starved;
        end
    end

    // Mark cycles with a valid history for the hold check.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> !ser_out);  // R4
    AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (ser_oe && !ser_out));  // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(tick)) |-> ($stable(ser_out) && $stable(ser_oe)));  // R2
    AST_DRIVEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !release_line) |=> ser_oe);  // R5

endmodule

// File: rtl/tdm_slot_tx.sv
// Module: tdm_slot_tx
// Top of the slot-based serial transmitter. It queues input words, tracks
// frame position and drives one serial bit per tick, with per-slot enables
// and a selectable idle behaviour.
// Assumes: a tick-rate enable from an external clock divider; configuration
// values obey the ranges in the brief.
module tdm_slot_tx #(
    parameter int MAX_SLOTS  = 16,
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 4,
    localparam int CNT_W     = $clog2(MAX_SLOTS + 1),
    localparam int LEN_W     = $clog2(WORD_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 frame_sync,
    input  logic [MAX_SLOTS-1:0] slot_enable_mask,
    input  logic [CNT_W-1:0]     slots_per_frame,
    input  logic [LEN_W-1:0]     slot_bits,
    input  logic [LEN_W-1:0]     data_bits,
    input  logic                 idle_hiz,
    input  logic [WORD_W-1:0]    word_in,
    input  logic                 word_valid,
    output logic                 word_ready,
    output logic                 ser_out,
    output logic                 ser_oe,
    output logic                 underrun
);
    logic              q_push;
    logic              q_pop;
    logic              q_empty;
    logic              q_full;
    logic [WORD_W-1:0] q_head;
    logic              pos_start;
    logic              pos_data;
    logic [LEN_W-1:0]  pos_bit;
    logic [LEN_W-1:0]  eff_data_len;
    logic              eff_release;

    // Accept a word whenever the queue has room.
    always_comb begin
        word_ready = !q_full;
        q_push     = word_valid && !q_full;
    end

    tdm_word_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (word_in),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    tdm_frame_tracker #(
        .MAX_SLOTS (MAX_SLOTS),
        .WORD_W    (WORD_W)
    ) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (bit_tick),
        .sync         (frame_sync),
        .cfg_mask     (slot_enable_mask),
        .cfg_slots    (slots_per_frame),
        .cfg_slot_len (slot_bits),
        .cfg_data_len (data_bits),
        .cfg_release  (idle_hiz),
        .pos_start    (pos_start),
        .pos_data     (pos_data),
        .pos_bit      (pos_bit),
        .eff_data_len (eff_data_len),
        .eff_release  (eff_release)
    );

    tdm_bit_driver #(
        .WORD_W (WORD_W)
    ) u_driver (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (bit_tick),
        .pos_start    (pos_start),
        .pos_data     (pos_data),
        .pos_bit      (pos_bit),
        .data_len     (eff_data_len),
        .release_line (eff_release),
        .q_empty      (q_empty),
        .q_head       (q_head),
        .q_pop        (q_pop),
        .ser_out      (ser_out),
        .ser_oe       (ser_oe),
        .underrun     (underrun)
    );

    AST_READY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop && !q_push) |=> word_ready);  // R9

endmodule

// File: tb/tb_tdm_slot_tx.sv
module tb_tdm_slot_tx;
    localparam int MAX_SLOTS  = 16;
    localparam int WORD_W     = 32;
    localparam int FIFO_DEPTH = 4;
    localparam int CNT_W      = $clog2(MAX_SLOTS + 1);
    localparam int LEN_W      = $clog2(WORD_W + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bit_tick = 1'b0;
    logic                 frame_sync = 1'b0;
    logic [MAX_SLOTS-1:0] slot_enable_mask = '0;
    logic [CNT_W-1:0]     slots_per_frame = CNT_W'(1);
    logic [LEN_W-1:0]     slot_bits = LEN_W'(8);
    logic [LEN_W-1:0]     data_bits = LEN_W'(8);
    logic                 idle_hiz = 1'b1;
    logic [WORD_W-1:0]    word_in = '0;
    logic                 word_valid = 1'b0;
    logic                 word_ready;
    logic                 ser_out;
    logic                 ser_oe;
    logic                 underrun;

    always #2 clk = ~clk;

    tdm_slot_tx #(
        .MAX_SLOTS  (MAX_SLOTS),
        .WORD_W     (WORD_W),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .bit_tick         (bit_tick),
        .frame_sync       (frame_sync),
        .slot_enable_mask (slot_enable_mask),
        .slots_per_frame  (slots_per_frame),
        .slot_bits        (slot_bits),
        .data_bits        (data_bits),
        .idle_hiz         (idle_hiz),
        .word_in          (word_in),
        .word_valid       (word_valid),
        .word_ready       (word_ready),
        .ser_out          (ser_out),
        .ser_oe           (ser_oe),
        .underrun         (underrun)
    );

    int checks = 0;
    int errors = 0;
    string phase_tag = "R1";
    int feed_mode = 0;   // 0 off, 1 random, 2 always
    bit finished = 1'b0;

    // Behavioural reference model state.
    int unsigned q[$];
    bit    m_in = 0;
    int    m_slot = 0, m_bit = 0;
    int    l_slots = 1, l_len = 1, l_dlen = 1;
    bit [MAX_SLOTS-1:0] l_mask = '0;
    bit    l_hiz = 1;
    int unsigned m_word = 0;
    bit    exp_out = 0, exp_oe = 0, exp_und = 0;
    string ctx = "R1";
    int    und_seen = 0;

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: one step per clock edge, using the inputs driven at the previous negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_in = 0; m_slot = 0; m_bit = 0; l_hiz = 1;
            exp_out = 0; exp_oe = 0; exp_und = 0; ctx = "R1";
        end else begin
            bit acc;
            acc = word_valid && (q.size() < FIFO_DEPTH);
            exp_und = 0;
            if (bit_tick) begin
                bit nv, act, dat;
                int ns, nb;
                nv = 0; ns = m_slot; nb = m_bit;
                if (frame_sync) begin
                    l_slots = int'(slots_per_frame); l_len = int'(slot_bits);
                    l_dlen = int'(data_bits); l_mask = slot_enable_mask; l_hiz = idle_hiz;
                    nv = 1; ns = 0; nb = 0;
                end else if (m_in) begin
                    if (m_bit + 1 < l_len) begin nv = 1; nb = m_bit + 1; end
                    else if (m_slot + 1 < l_slots) begin nv = 1; ns = m_slot + 1; nb = 0; end
                end
                act = nv && l_mask[ns];
                dat = act && (nb < l_dlen);
                if (act && nb == 0) begin
                    if (q.size() > 0) m_word = q.pop_front();
                    else begin m_word = 0; exp_und = 1; end
                end
                if (dat) begin
                    exp_oe = 1; exp_out = m_word[l_dlen - 1 - nb];
                    ctx = exp_und ? "R7" : "R3";
                end else begin
                    exp_oe = !l_hiz; exp_out = 0;
                    ctx = l_hiz ? "R4" : "R5";
                end
                m_in = nv; m_slot = ns; m_bit = nb;
            end else begin
                ctx = "R2";
            end
            if (acc) q.push_back(word_in);
        end
    end

    // Compare every output against the model on every cycle after reset.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check({ctx, "/", phase_tag}, ser_oe, exp_oe, "ser_oe");
            check({ctx, "/", phase_tag}, ser_out, exp_out, "ser_out");
            check({"R7/", phase_tag}, underrun, exp_und, "underrun");
            check({"R9/", phase_tag}, word_ready, (q.size() < FIFO_DEPTH), "word_ready");
            if (underrun) und_seen++;
        end
    end

    // Input word feeder.
    always @(negedge clk) begin
        word_in    <= $urandom;
        word_valid <= (feed_mode == 2) || (feed_mode == 1 && ($urandom_range(0, 2) != 0));
    end

    task automatic run_ticks(input int n, input bit with_sync, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_tick = 1'b1;
            frame_sync = with_sync && (i == 0);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                bit_tick = 1'b0;
                frame_sync = 1'b0;
            end
        end
        @(negedge clk);
        bit_tick = 1'b0;
        frame_sync = 1'b0;
    endtask

    task automatic set_cfg(input int ns, input int sl, input int dl, input logic [MAX_SLOTS-1:0] m, input bit hz);
        slots_per_frame = CNT_W'(ns); slot_bits = LEN_W'(sl); data_bits = LEN_W'(dl);
        slot_enable_mask = m; idle_hiz = hz;
    endtask

    task automatic frames(input int count, input int gap);
        for (int f = 0; f < count; f++) begin
            run_ticks(int'(slots_per_frame) * int'(slot_bits), 1'b1, gap);
            run_ticks(3, 1'b0, gap);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values while reset is held
        check("R1", ser_oe, 1'b0, "ser_oe in reset");
        check("R1", ser_out, 1'b0, "ser_out in reset");
        check("R1", underrun, 1'b0, "underrun in reset");
        check("R1", word_ready, 1'b1, "word_ready in reset");
        rst_n = 1'b1;

        // R3, R4: enabled slots 0,1,3 of 4, full-width data, released idle
        phase_tag = "R3";
        set_cfg(4, 8, 8, 16'h000B, 1'b1);
        feed_mode = 1;
        repeat (6) @(negedge clk);
        frames(3, 0);

        // R6, R5: slot wider than data, idle driven low, tick every other cycle
        phase_tag = "R6";
        set_cfg(3, 12, 5, 16'h0006, 1'b0);
        frames(3, 1);

        // R2: sparse ticks, full 32-bit slots, outputs must hold between ticks
        phase_tag = "R2";
        set_cfg(2, 32, 32, 16'h0003, 1'b1);
        frames(2, 2);

        // R7: starve the queue so enabled slots see no word
        phase_tag = "R7";
        feed_mode = 0;
        und_seen = 0;
        set_cfg(4, 4, 4, 16'h000F, 1'b0);
        frames(3, 0);
        checks++;
        if (und_seen == 0) begin
            errors++;
            $display("FAIL R7 underrun pulses: actual %0d expected >0", und_seen);
        end

        // R8: change geometry mid-frame; the old geometry must finish the frame
        phase_tag = "R8";
        feed_mode = 1;
        set_cfg(4, 6, 6, 16'h0005, 1'b1);
        run_ticks(10, 1'b1, 0);
        set_cfg(2, 9, 3, 16'h0002, 1'b0);
        run_ticks(24 - 10 + 4, 1'b0, 0);
        frames(2, 0);

        // R10: frame sync mid-frame restarts at slot 0
        phase_tag = "R10";
        set_cfg(5, 8, 7, 16'h001F, 1'b1);
        run_ticks(13, 1'b1, 0);
        run_ticks(40 + 3, 1'b1, 0);

        // R9: fill the queue with no ticks and check backpressure
        phase_tag = "R9";
        feed_mode = 2;
        repeat (FIFO_DEPTH + 3) @(negedge clk);
        check("R9", word_ready, 1'b0, "word_ready when queue full");
        feed_mode = 0;
        set_cfg(MAX_SLOTS, 2, 1, 16'hFFFF, 1'b0);
        frames(1, 0);
        check("R9", word_ready, 1'b1, "word_ready after drain");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule